// File: doc/BRIEF.md
# Reloading Interval Timer Channel

One timer channel that divides a count-clock enable into periodic interrupt pulses and a square wave. Software programs a period value. Once started, the channel loads that value into a down-counter. The counter steps down on every selected count-clock enable, and each time it passes through zero the period is reloaded. Every zero pass raises a one-cycle interrupt pulse and flips the timer output. A period of N gives N+1 count clocks between interrupts, so the square wave lasts 2(N+1) count clocks.

Software reaches the channel through a small register port. Start and stop are one-shot trigger bits. The counter can be read back at any moment. A mode bit selects whether the first load after a start also raises an interrupt and a toggle. Configuration that would upset a running count is frozen while the channel runs. The period value can still be changed, and a new value takes effect at the next reload. A unit enable input wipes the whole channel back to its idle state. The count clock comes from one of two external prescaler enable pulses, each one system clock wide.

Register map: address 0 holds the period. Address 1 is the mode register: bit 0 is the start-interrupt bit and bit 1 is the clock select. Address 2 is output control: bit 0 is the output bit, bit 1 is the output enable and bit 2 is the output invert. Address 3 is control and status: bit 0 is the start trigger, bit 1 is the stop trigger and bit 2 reads the running status. Address 4 reads the counter.

Top module: `interval_timer_chan`

## Requirements
- R1: While running, each selected count-clock enable decrements the counter by one. The enable after the counter has reached 0 reloads it from the period register, so a period of N yields N+1 enables between zero events.
- R2: Each zero event drives `intPulse` high for exactly the one cycle after the enable edge. If the output is enabled, the same event inverts the output bit.
- R3: Writing 1 to control bit 0 sets the running status. The first selected enable after that loads the period into the counter. This first load raises an interrupt and a toggle only when mode bit 0 is 1.
- R4: Control bits 0 and 1 always read as 0. Bit 2 reads the running status. If both triggers are written together, the stop trigger wins.
- R5: Writing 1 to control bit 1 clears the running status. The counter then keeps its value, and `tmrOut` keeps its level while further enables arrive.
- R6: The period register accepts writes at any time. A value written while running is first used at the next reload.
- R7: While running, writes to the mode register and to the output-invert bit (address 2 bit 2) are ignored. The output enable stays writable.
- R8: The counter value reads at address 4 whether the channel is running or stopped.
- R9: The output bit takes software writes only while the output enable is 0. `tmrOut` equals the output bit XOR the invert bit when enabled, and 0 when disabled.
- R10: Mode bit 1 = 0 selects `tickA` and mode bit 1 = 1 selects `tickB`. Enables on the unselected input have no effect.
- R11: With `unitEn` low at a clock edge, every register returns to 0, including the output bit, and `tmrOut` drops to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| unitEn | input | 1 | Unit enable; low clears the channel |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | CNT_W | Register write data |
| rdAddr | input | 3 | Register read address |
| rdData | output | CNT_W | Register read data (combinational) |
| tickA | input | 1 | Prescaler enable pulse, source 0 |
| tickB | input | 1 | Prescaler enable pulse, source 1 |
| intPulse | output | 1 | One-cycle interrupt pulse |
| tmrOut | output | 1 | Square-wave timer output |

## Verification
If the counter, the first-load flag or the running bit goes wrong, the error shows up at address 4 on the very next selected enable. It also shows as an `intPulse` that comes one enable early, comes late, or never comes. The bench therefore follows every enable through several full periods and compares the counter, the pulse and the output after each one. A lock or write-acceptance fault is only visible through a read-back or through `tmrOut`, so each ignored write is followed at once by a read of the register it aimed at and a sample of the output.

// File: rtl/itc_pkg.sv
package itc_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_PERIOD = 3'd0,
    A_MODE   = 3'd1,
    A_OUT    = 3'd2,
    A_CTRL   = 3'd3,
    A_COUNT  = 3'd4
  } regAddr_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clr;     // unit clear
    logic load;    // copy period into counter
    logic dec;     // step counter down
    logic evt;     // zero event: raise interrupt
    logic toggle;  // invert output bit
    logic outWr;   // software write of output bit
    logic outVal;  // value for software write
  } dpStrb_t;
endpackage

// File: rtl/itc_ctrl.sv
module itc_ctrl
  import itc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              unitEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic              tickA,
  input  logic              tickB,
  input  logic              cntZero,
  output dpStrb_t           strb,
  output logic [CNT_W-1:0]  periodO,
  output logic              runO,
  output logic              startIrqO,
  output logic              clkSelO,
  output logic              outEnO,
  output logic              outInvO
);
  localparam int NUM_SRC = 2;

  logic [CNT_W-1:0] periodQ;
  logic startIrqQ, clkSelQ, outEnQ, outInvQ, runQ, needLoadQ;
  logic [NUM_SRC-1:0] tickVec;
  logic tickSel, active;
  logic wrPeriod, wrMode, wrOut, wrCtrl, trigStart, trigStop;

  assign tickVec = {tickB, tickA};
  assign tickSel = tickVec[clkSelQ];
  assign active  = runQ & tickSel & unitEn;

  assign wrPeriod  = wrEn & (wrAddr == A_PERIOD);
  assign wrMode    = wrEn & (wrAddr == A_MODE);
  assign wrOut     = wrEn & (wrAddr == A_OUT);
  assign wrCtrl    = wrEn & (wrAddr == A_CTRL);
  assign trigStart = wrCtrl & wrData[0];
  assign trigStop  = wrCtrl & wrData[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodQ   <= '0;
      startIrqQ <= 1'b0;
      clkSelQ   <= 1'b0;
      outEnQ    <= 1'b0;
      outInvQ   <= 1'b0;
      runQ      <= 1'b0;
      needLoadQ <= 1'b0;
    end else if (!unitEn) begin
      periodQ   <= '0;
      startIrqQ <= 1'b0;
      clkSelQ   <= 1'b0;
      outEnQ    <= 1'b0;
      outInvQ   <= 1'b0;
      runQ      <= 1'b0;
      needLoadQ <= 1'b0;
    end else begin
      if (wrPeriod) periodQ <= wrData;
      if (wrMode && !runQ) begin
        startIrqQ <= wrData[0];
        clkSelQ   <= wrData[1];
      end
      if (wrOut) begin
        outEnQ <= wrData[1];
        if (!runQ) outInvQ <= wrData[2];
      end
      if (trigStop) begin
        runQ      <= 1'b0;
        needLoadQ <= 1'b0;
      end else if (trigStart) begin
        runQ      <= 1'b1;
        needLoadQ <= 1'b1;
      end else if (active) begin
        needLoadQ <= 1'b0;
      end
    end
  end

  always_comb begin
    strb        = '0;
    strb.clr    = ~unitEn;
    strb.load   = active & (needLoadQ | cntZero);
    strb.dec    = active & ~needLoadQ & ~cntZero;
    strb.evt    = active & ((needLoadQ & startIrqQ) | (~needLoadQ & cntZero));
    strb.toggle = strb.evt & outEnQ;
    strb.outWr  = wrOut & ~outEnQ & unitEn;
    strb.outVal = wrData[0];
  end

  assign periodO   = periodQ;
  assign runO      = runQ;
  assign startIrqO = startIrqQ;
  assign clkSelO   = clkSelQ;
  assign outEnO    = outEnQ;
  assign outInvO   = outInvQ;

  // R7
  mode_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runQ && unitEn) |=> ($stable(startIrqQ) && $stable(clkSelQ) && $stable(outInvQ)));

  // R1
  strb_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.load, strb.dec}));

  // R4
  stop_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trigStop && unitEn) |=> !runQ);
endmodule

// File: rtl/itc_datapath.sv
module itc_datapath
  import itc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrb_t          strb,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic             cntZero,
  output logic             outBit,
  output logic             intPulse
);
  logic [CNT_W-1:0] cntQ;
  logic outBitQ, intQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ    <= '0;
      outBitQ <= 1'b0;
      intQ    <= 1'b0;
    end else if (strb.clr) begin
      cntQ    <= '0;
      outBitQ <= 1'b0;
      intQ    <= 1'b0;
    end else begin
      if (strb.load)      cntQ <= period;
      else if (strb.dec)  cntQ <= cntQ - 1'b1;
      if (strb.toggle)     outBitQ <= ~outBitQ;
      else if (strb.outWr) outBitQ <= strb.outVal;
      intQ <= strb.evt;
    end
  end

  assign cnt      = cntQ;
  assign cntZero  = (cntQ == '0);
  assign outBit   = outBitQ;
  assign intPulse = intQ;

  // R1
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.dec |-> (cntQ != '0));

  // R9
  out_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.toggle && strb.outWr));
endmodule

// File: rtl/interval_timer_chan.sv
module interval_timer_chan
  import itc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             unitEn,
  input  logic             wrEn,
  input  logic [2:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic [2:0]       rdAddr,
  output logic [CNT_W-1:0] rdData,
  input  logic             tickA,
  input  logic             tickB,
  output logic             intPulse,
  output logic             tmrOut
);
  dpStrb_t strb;
  logic [CNT_W-1:0] period, cnt;
  logic cntZero, outBit, running, startIrq, clkSel, outEn, outInv;

  itc_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .unitEn(unitEn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .tickA(tickA), .tickB(tickB), .cntZero(cntZero),
    .strb(strb), .periodO(period), .runO(running), .startIrqO(startIrq),
    .clkSelO(clkSel), .outEnO(outEn), .outInvO(outInv)
  );

  itc_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .period(period), .cnt(cnt),
    .cntZero(cntZero), .outBit(outBit), .intPulse(intPulse)
  );

  assign tmrOut = outEn & (outBit ^ outInv);

  always_comb begin
    rdData = '0;
    case (rdAddr)
      A_PERIOD: rdData = period;
      A_MODE:   rdData[1:0] = {clkSel, startIrq};
      A_OUT:    rdData[2:0] = {outInv, outEn, outBit};
      A_CTRL:   rdData[2] = running;
      A_COUNT:  rdData = cnt;
      default:  rdData = '0;
    endcase
  end

  // R2
  toggle_on_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intPulse && outEn && $past(outEn)) |-> (tmrOut != $past(tmrOut)));

  // R5
  hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!running && unitEn) |=> $stable(cnt));

  // R11
  unit_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !unitEn |=> (!tmrOut && !intPulse && cnt == '0));
endmodule

// File: tb/test_interval_timer_chan.sv
module test_interval_timer_chan;
  localparam int W = 16;

  logic clk = 1'b0, rstN = 1'b0, unitEn = 1'b0, wrEn = 1'b0, tickA = 1'b0, tickB = 1'b0;
  logic [2:0] wrAddr = '0, rdAddr = '0;
  logic [W-1:0] wrData = '0;
  logic [W-1:0] rdData;
  logic intPulse, tmrOut;

  interval_timer_chan #(.CNT_W(W)) i_interval_timer_chan (
    .clk(clk), .rstN(rstN), .unitEn(unitEn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .tickA(tickA),
    .tickB(tickB), .intPulse(intPulse), .tmrOut(tmrOut)
  );

  always #5 clk = ~clk;

  int nChk = 0, nErr = 0;
  int mPer = 0, mCnt = 0;
  bit mIrq, mSel, mEn, mInv, mBit, mRun, mNeed;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit expOut();
    return mEn & (mBit ^ mInv);
  endfunction

  task automatic rdChk(logic [2:0] a, int exp, string tag);
    rdAddr = a;
    #1 check(tag, 32'(rdData), exp);
  endtask

  task automatic wr(logic [2:0] a, int d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = W'(d);
    @(negedge clk);
    wrEn = 1'b0;
    case (a)
      3'd0: mPer = d;
      3'd1: if (!mRun) begin mIrq = d[0]; mSel = d[1]; end
      3'd2: begin
        if (!mRun) mInv = d[2];
        if (!mEn) mBit = d[0];
        mEn = d[1];
      end
      3'd3: if (d[1]) begin mRun = 0; mNeed = 0; end
            else if (d[0]) begin mRun = 1; mNeed = 1; end
      default: ;
    endcase
  endtask

  task automatic tick(bit line, string tag);
    bit evt;
    @(negedge clk);
    if (line) tickB = 1'b1; else tickA = 1'b1;
    @(negedge clk);
    tickA = 1'b0; tickB = 1'b0;
    evt = 0;
    if (mRun && line == mSel) begin
      if (mNeed) begin mCnt = mPer; mNeed = 0; evt = mIrq; end
      else if (mCnt == 0) begin mCnt = mPer; evt = 1; end
      else mCnt--;
      if (evt && mEn) mBit = ~mBit;
    end
    #1 check({tag, " intPulse"}, 32'(intPulse), 32'(evt));
    rdChk(3'd4, mCnt, {tag, " R8 counter"});
    check({tag, " tmrOut"}, 32'(tmrOut), 32'(expOut()));
    @(negedge clk);
    #1 check({tag, " R2 pulse width"}, 32'(intPulse), 0);
  endtask

  initial begin
    #(200000 * 10);
    nChk++; nErr++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", nChk, nErr);
    $finish;
  end

  initial begin
    #22 rstN = 1'b1;
    @(negedge clk);
    rdChk(3'd4, 0, "reset counter");
    rdChk(3'd3, 0, "reset status");
    check("reset tmrOut", 32'(tmrOut), 0);
    check("reset intPulse", 32'(intPulse), 0);
    unitEn = 1'b1;

    // sweep periods and start-interrupt mode (R1 R2 R3 R9)
    for (int n = 0; n < 5; n++) begin
      for (int irq = 0; irq < 2; irq++) begin
        wr(3'd3, 2);
        wr(3'd1, irq);
        wr(3'd0, n);
        wr(3'd2, 1);
        #1 check("R9 disabled output", 32'(tmrOut), 0);
        wr(3'd2, 3);
        #1 check("R9 default level", 32'(tmrOut), 1);
        wr(3'd3, 1);
        rdChk(3'd3, 4, "R4 R3 running status");
        for (int k = 0; k < 2 * (n + 1) + 2; k++) tick(1'b0, "R1 R3 sweep");
      end
    end

    // stop holds counter and output (R5)
    wr(3'd3, 2);
    rdChk(3'd3, 0, "R4 R5 stopped status");
    repeat (3) tick(1'b0, "R5 hold");

    // lock while running (R7, R10)
    wr(3'd0, 3);
    wr(3'd1, 0);
    wr(3'd2, 2);
    wr(3'd3, 1);
    repeat (3) tick(1'b0, "R1 run");
    wr(3'd1, 3);
    rdChk(3'd1, 0, "R7 mode locked");
    wr(3'd2, 6);
    rdChk(3'd2, {29'd0, 1'b0, 1'b1, mBit}, "R7 invert locked");
    check("R7 tmrOut", 32'(tmrOut), 32'(expOut()));
    tick(1'b1, "R10 unselected ignored");
    tick(1'b0, "R7 still counting");

    // period rewrite mid-count (R6)
    wr(3'd0, 6);
    rdChk(3'd0, 6, "R6 period readback");
    repeat (12) tick(1'b0, "R6 new period");

    // both triggers: stop wins (R4)
    wr(3'd3, 3);
    rdChk(3'd3, 0, "R4 stop wins");
    tick(1'b0, "R4 R5 stopped");

    // clock select (R10)
    wr(3'd1, 2);
    rdChk(3'd1, 2, "R10 select written");
    wr(3'd3, 1);
    tick(1'b0, "R10 tickA ignored");
    repeat (9) tick(1'b1, "R10 tickB");

    // output bit write while enabled ignored (R9)
    wr(3'd2, {30'd0, 1'b1, ~mBit});
    check("R9 outBit write ignored", 32'(tmrOut), 32'(expOut()));

    // unit clear (R11)
    @(negedge clk); unitEn = 1'b0;
    @(negedge clk); unitEn = 1'b1;
    mPer = 0; mCnt = 0; mIrq = 0; mSel = 0; mEn = 0; mInv = 0; mBit = 0; mRun = 0; mNeed = 0;
    for (int a = 0; a < 5; a++) rdChk(3'(a), 0, "R11 cleared register");
    check("R11 tmrOut", 32'(tmrOut), 0);
    tick(1'b0, "R11 idle after clear");

    $display("Simulation finished: %0d checks, %0d errors", nChk, nErr);
    $finish;
  end
endmodule